// File: doc/BRIEF.md
# Size-Agnostic Register Bus Word Adapter

This block sits between a 32-bit multiplexed processor bus and an internal register file whose entries are all full 32-bit words. The processor issues a request with an address, an access size (8, 16, 32 or 64 bits), a direction, a cacheable flag and a data word. The adapter discards the access size and the two lowest address bits. It always reads or writes one whole aligned register word and answers after a fixed number of cycles. A decode input chosen by the requester selects one of two latencies: a short one for a fast register group and a long one for standard registers.

The adapter does not re-merge narrow writes. A byte or halfword store writes the lane-shifted bus word into the register exactly as it arrived, so upper bytes of the source register reach the hardware register. A 64-bit store writes only its first (upper) word. The second word, which the requester presents in the cycle after acceptance, is dropped. A 64-bit load gets one reply word and never a second, so the requester waits forever. Cacheable requests are dropped outright and get no reply. The register file behind the adapter sees a word address, a one-cycle write strobe with all byte enables set, and a read port that the adapter samples when it answers.

Top module: `regbus_word_adapter`

## Requirements
- R1: For every accepted request, `rf_addr` equals `req_addr` with bits [1:0] forced to zero, from the cycle after acceptance until the reply.
- R2: A read of size 8 (`req_size`=00), 16 (01) or 32 (10) returns the whole 32-bit register word at the aligned address on `rsp_data`.
- R3: A write of any size stores `req_wdata` unchanged into the aligned register. The strobe has `rf_be`=4'hF. Example: 0x5678_0000 sent to 0x0460_0011 as a byte store lands verbatim in the register at 0x0460_0010.
- R4: A 64-bit write (`req_size`=11) stores only the word presented with the request. The word on `req_wdata` in the following cycle is never written, and exactly one reply is produced.
- R5: `rf_we` is high for exactly one cycle per accepted write: the cycle after acceptance. Reads never raise it.
- R6: A request with `req_cached`=1 is dropped. No write strobe and no reply follow, and `req_ready` stays high.
- R7: A 64-bit read produces exactly one `rsp_valid` pulse carrying the aligned register word, and no second one.
- R8: `rsp_valid` is a one-cycle pulse, FAST_LAT cycles after the acceptance edge when `req_fast`=1 and SLOW_LAT cycles after it when `req_fast`=0. `rsp_data` is zero in a write's reply.
- R9: `req_ready` is low from the cycle after acceptance up to the reply cycle, where it is high again. Requests offered while it is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle and able to accept |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | Access size: 00=8, 01=16, 10=32, 11=64 bits (ignored) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cached | input | 1 | Cacheable request (dropped) |
| req_fast | input | 1 | Target is in the fast register group |
| req_wdata | input | 32 | Write data word (lane-shifted by the requester) |
| rsp_valid | output | 1 | Reply pulse |
| rsp_data | output | 32 | Reply word (zero for writes) |
| rf_addr | output | 32 | Aligned register word address |
| rf_we | output | 1 | One-cycle write strobe |
| rf_be | output | 4 | Byte enables, always all set |
| rf_wdata | output | 32 | Word written to the register file |
| rf_rdata | input | 32 | Register file read data for `rf_addr` |

## Verification
If the latency counter loads the wrong value, `rsp_valid` lands a cycle early or late and `req_ready` returns at the same wrong edge. The mismatch is visible within SLOW_LAT cycles of the acceptance. If the stored operation kind is wrong, the strobe fires on a read or a write reply carries data, and this is seen on the cycle after acceptance or at the reply. Alignment or data capture errors leave the wrong word in the register file. That shows up on the next read of that address or of its neighbour, which is how dropped 64-bit second words and ignored busy-time requests are checked.

// File: rtl/regbus_adapt_pkg.sv
package regbus_adapt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  // Word address: byte address with the lane bits cleared.
  function automatic logic [31:0] word_align(input logic [31:0] byte_addr);
    return {byte_addr[31:2], 2'b00};
  endfunction

  // Latency in cycles for the selected register group.
  function automatic int unsigned pick_lat(input logic fast,
                                           input int unsigned fast_lat,
                                           input int unsigned slow_lat);
    return fast ? fast_lat : slow_lat;
  endfunction

endpackage

// File: rtl/rba_decode.sv
module rba_decode
  import regbus_adapt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       idle,
  input  logic       req_cached,
  input  logic       req_write,
  input  logic [1:0] req_size,
  output logic       accept,
  output logic       drop
);

  assign drop   = req_valid && idle && req_cached;
  assign accept = req_valid && idle && !req_cached;

  // R7: a 64-bit read is taken like any other read and leaves the adapter busy
  a_r7_dword_read_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && (req_size == SZ_DWORD)) |=> !idle);

  // R6: a dropped request never starts an access
  a_r6_cached_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> idle);

endmodule

// File: rtl/rba_timer.sv
module rba_timer
  import regbus_adapt_pkg::*;
#(
  parameter int unsigned FAST_LAT = 2,
  parameter int unsigned SLOW_LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  output logic busy,
  output logic done
);

  localparam int unsigned MAX_LAT = (FAST_LAT > SLOW_LAT) ? FAST_LAT : SLOW_LAT;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] remain;

  assign done = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= CNT_W'(pick_lat(fast, FAST_LAT, SLOW_LAT) - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  // R8: the count only runs down while busy, and busy holds until it reaches zero
  a_r8_hold_until_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (remain != '0)) |=> (busy && (remain == $past(remain) - 1'b1)));

  a_r8_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

endmodule

// File: rtl/rba_rf_drive.sv
module rba_rf_drive
  import regbus_adapt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              op_write
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_addr  <= '0;
      rf_wdata <= '0;
      rf_we    <= 1'b0;
      op_write <= 1'b0;
    end else begin
      rf_we <= accept && req_write;
      if (accept) begin
        rf_addr  <= word_align(req_addr);
        rf_wdata <= req_wdata;
        op_write <= req_write;
      end
    end
  end

  // R5: the write strobe never lasts past one cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R5: reads never strobe
  a_r5_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> !rf_we);

  // R3: the stored word is the request word unchanged
  a_r3_verbatim_data: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (rf_wdata == $past(req_wdata)));

endmodule

// File: rtl/regbus_word_adapter.sv
module regbus_word_adapter
  import regbus_adapt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FAST_LAT = 2,
  parameter int unsigned SLOW_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_cached,
  input  logic              req_fast,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W/8-1:0] rf_be,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);

  localparam int unsigned BE_W = DATA_W / 8;

  logic accept;
  logic drop;
  logic busy;
  logic done;
  logic op_write;

  assign req_ready = !busy;
  assign rf_be     = {BE_W{1'b1}};

  rba_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .idle       (req_ready),
    .req_cached (req_cached),
    .req_write  (req_write),
    .req_size   (req_size),
    .accept     (accept),
    .drop       (drop)
  );

  rba_timer #(
    .FAST_LAT (FAST_LAT),
    .SLOW_LAT (SLOW_LAT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .fast  (req_fast),
    .busy  (busy),
    .done  (done)
  );

  rba_rf_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rf_addr   (rf_addr),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata),
    .op_write  (op_write)
  );

  // Reply stage: one pulse per access, read data sampled at the final count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done;
      if (done) rsp_data <= op_write ? '0 : rf_rdata;
    end
  end

  // R7 / R8: the reply is a single pulse
  a_r7_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: the adapter is busy right after taking a request
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R9: ready returns together with the reply
  a_r9_ready_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R6: a dropped request yields neither strobe nor reply
  a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!rf_we && !rsp_valid));

  // R1: the register word address is aligned and stable while busy
  a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(rf_addr));

endmodule

// File: tb/tb_regbus_word_adapter.sv
`timescale 1ns/1ps
module tb_regbus_word_adapter;

  localparam int FAST = 2;
  localparam int SLOW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_cached = 1'b0;
  logic        req_fast = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] rf_addr;
  logic        rf_we;
  logic [3:0]  rf_be;
  logic [31:0] rf_wdata;
  logic [31:0] rf_rdata;

  logic [31:0] mem [16];
  int n_checks = 0;
  int n_fails  = 0;
  int we_cnt   = 0;
  int rsp_cnt  = 0;
  int cycles   = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  regbus_word_adapter #(.FAST_LAT(FAST), .SLOW_LAT(SLOW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_cached(req_cached), .req_fast(req_fast), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rf_addr(rf_addr),
    .rf_we(rf_we), .rf_be(rf_be), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // Behavioural register file
  assign rf_rdata = mem[rf_addr[5:2]];
  always @(posedge clk) begin
    if (rf_we) begin
      mem[rf_addr[5:2]] <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    req_valid = 1'b0; req_cached = 1'b0; req_write = 1'b0;
  endtask

  // One access; inputs driven at negedge, outputs sampled at negedge.
  task automatic run_req(input logic [31:0] addr, input logic [1:0] size,
                         input bit wr, input bit fast, input logic [31:0] wd,
                         input logic [31:0] wd2, input logic [31:0] exp_rd,
                         input bit inject);
    int lat = fast ? FAST : SLOW;
    int we0;
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_size = size; req_write = wr;
    req_cached = 0; req_fast = fast; req_wdata = wd;
    we0 = we_cnt;
    @(posedge clk);
    @(negedge clk);
    idle_bus();
    req_wdata = wd2;
    check(rf_addr == {addr[31:2], 2'b00}, "R1 aligned rf_addr", rf_addr, {addr[31:2], 2'b00});
    check(req_ready == 0, "R9 ready low when busy", 32'(req_ready), 0);
    check(rf_we == wr, "R5 strobe after accept", 32'(rf_we), 32'(wr));
    if (wr) begin
      check(rf_be == 4'hF, "R3 all bytes enabled", 32'(rf_be), 32'hF);
      check(rf_wdata == wd, "R3 verbatim word", rf_wdata, wd);
    end
    if (inject) begin
      req_valid = 1; req_write = 1; req_addr = 32'h0460_0030; req_wdata = 32'hBAD0_BAD0;
    end
    for (int i = 1; i < lat; i++) begin
      @(posedge clk);
      @(negedge clk);
      idle_bus();
      check(rsp_valid == 0, "R8 no early reply", 32'(rsp_valid), 0);
      check(rf_we == 0, "R5 strobe one cycle", 32'(rf_we), 0);
    end
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1, "R8 reply at latency", 32'(rsp_valid), 1);
    check(req_ready == 1, "R9 ready with reply", 32'(req_ready), 1);
    check(rsp_data == (wr ? 32'h0 : exp_rd), wr ? "R8 write reply zero" : "R2 read word",
          rsp_data, wr ? 32'h0 : exp_rd);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 0, "R8 reply one cycle", 32'(rsp_valid), 0);
    check(we_cnt - we0 == (wr ? 1 : 0), "R5 strobe count", 32'(we_cnt - we0), wr ? 1 : 0);
  endtask

  task automatic t_reset();
    check(req_ready == 1, "R9 reset ready", 32'(req_ready), 1);
    check(rsp_valid == 0, "R8 reset no reply", 32'(rsp_valid), 0);
    check(rf_we == 0, "R5 reset no strobe", 32'(rf_we), 0);
  endtask

  task automatic t_word_write_read();
    run_req(32'h0460_0008, 2'b10, 1, 0, 32'hA5A5_1234, 0, 0, 0);
    run_req(32'h0460_000B, 2'b00, 0, 0, 0, 0, 32'hA5A5_1234, 0); // R2 byte read
  endtask

  task automatic t_narrow_write();
    run_req(32'h0460_0011, 2'b00, 1, 1, 32'h5678_0000, 0, 0, 0); // R3 example
    run_req(32'h0460_0012, 2'b01, 0, 1, 0, 0, 32'h5678_0000, 0); // R2 half read
    check(mem[4] == 32'h5678_0000, "R3 stored at aligned word", mem[4], 32'h5678_0000);
  endtask

  task automatic t_dword_write();
    int r0 = rsp_cnt;
    run_req(32'h0460_0020, 2'b11, 1, 1, 32'h1111_2222, 32'h3333_4444, 0, 0);
    check(rsp_cnt - r0 == 1, "R4 one reply", 32'(rsp_cnt - r0), 1);
    run_req(32'h0460_0024, 2'b10, 0, 1, 0, 0, 32'h0, 0); // R4 second word dropped
    run_req(32'h0460_0020, 2'b10, 0, 0, 0, 0, 32'h1111_2222, 0); // R4 first word kept
  endtask

  task automatic t_dword_read();
    int r0 = rsp_cnt;
    run_req(32'h0460_0020, 2'b11, 0, 0, 0, 0, 32'h1111_2222, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(rsp_cnt - r0 == 1, "R7 no second reply", 32'(rsp_cnt - r0), 1);
  endtask

  task automatic t_cached();
    int w0 = we_cnt;
    int r0 = rsp_cnt;
    @(negedge clk);
    req_valid = 1; req_cached = 1; req_write = 1; req_addr = 32'h0460_0008;
    req_size = 2'b10; req_wdata = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    idle_bus();
    check(req_ready == 1, "R6 ready stays high", 32'(req_ready), 1);
    req_valid = 1; req_cached = 1; req_write = 0;
    @(posedge clk);
    @(negedge clk);
    idle_bus();
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(we_cnt == w0, "R6 no strobe", 32'(we_cnt - w0), 0);
    check(rsp_cnt == r0, "R6 no reply", 32'(rsp_cnt - r0), 0);
    run_req(32'h0460_0008, 2'b10, 0, 1, 0, 0, 32'hA5A5_1234, 0); // R6 word untouched
  endtask

  task automatic t_busy_ignore();
    run_req(32'h0460_0004, 2'b10, 1, 0, 32'h0BAD_F00D, 0, 0, 1);
    run_req(32'h0460_0030, 2'b10, 0, 1, 0, 0, 32'h0, 0); // R9 injected write ignored
    run_req(32'h0460_0004, 2'b10, 0, 1, 0, 0, 32'h0BAD_F00D, 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000 && !done_run) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_word_write_read();
    t_narrow_write();
    t_dword_write();
    t_dword_read();
    t_cached();
    t_busy_ignore();
    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule